// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital side of a 100-position digitally controlled potentiometer. A host drives three asynchronous pins: an active-low select, a step strobe and a direction level. The block brings them into the system clock domain and keeps a tap index that moves one place on each falling strobe edge while the block is selected. It decodes that index into a one-hot tap-select vector. The index stops at either end of the range and never wraps.

On deselect, the level of the strobe decides whether the position is saved. With the strobe high, the current index is copied into a retained register that models non-volatile storage, and a busy interval begins. During that interval strobe edges are ignored. With the strobe low, nothing is written, and the live position stays in effect until the next power cycle.

Two resets are provided. `pwr_rst_n` models a power cycle: it clears the control logic and, once released, reloads the index from the retained register. `cold_rst_n` also blanks the retained register to a mid-scale default, modelling a never-written cell. No data stream passes through the block, so every pin is a plain level.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After `cold_rst_n` the position is BLANK_POS (50). After a `pwr_rst_n` pulse alone, the position equals the value held in the retained register.
- R2: With select low, a falling strobe edge while `dir_up` is 1 raises the position by one.
- R3: With select low, a falling strobe edge while `dir_up` is 0 lowers the position by one.
- R4: Stepping up at position 99 leaves the position at 99.
- R5: Stepping down at position 0 leaves the position at 0.
- R6: Strobe edges while `sel_n` is high do not change the position.
- R7: A rising `sel_n` while the strobe is high copies the position into the retained register. It then holds `store_busy` high for STORE_CYCLES clocks, after which the signal drops.
- R8: A rising `sel_n` while the strobe is low stores nothing and raises no busy. The live position is kept until the next power cycle.
- R9: Falling strobe edges while `store_busy` is high are ignored. Steps resume once it drops.
- R10: `tap_sel` has exactly one bit set, at the index equal to `wiper_pos` (bit 0 = tap 0).
- R11: `dir_up` may change between strobe pulses while select stays low. Each step follows the level present at its own strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Active-low reset that also blanks the retained register |
| pwr_rst_n | input | 1 | Active-low power-cycle reset; retained register survives |
| sel_n | input | 1 | Asynchronous active-low select |
| strobe | input | 1 | Asynchronous step strobe, acts on its falling edge |
| dir_up | input | 1 | Asynchronous direction level, 1 = up, 0 = down |
| wiper_pos | output | 7 | Current tap index, 0 to 99 |
| tap_sel | output | 100 | One-hot tap select |
| store_busy | output | 1 | High while a store interval runs |

## Verification
The hardest case to reach is a strobe edge that arrives while a store is still busy. That state exists only for a bounded window after a deselect with the strobe high. The bench shortens the store interval through its parameter, reselects the block at once and pulses the strobe inside the window. It then reads the unchanged position while `store_busy` is still high. A discarded store is equally hidden, since the live position looks the same either way. The bench exposes it by pulsing `pwr_rst_n` and comparing the recalled position against the last value that was truly stored.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  typedef struct packed {
    logic sel_n;
    logic strobe;
    logic dir_up;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, strobe: 1'b1, dir_up: 1'b0};

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/wiper_step_ctr.sv
module wiper_step_ctr
  import wiper_pkg::*;
#(
  parameter int NUM_TAPS = 100,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] load_pos,
  input  step_e            step_cmd,
  output logic [POS_W-1:0] pos,
  output logic             pos_valid
);

  localparam logic [POS_W-1:0] TOP_POS = POS_W'(NUM_TAPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      pos_valid <= 1'b0;
    end else if (!pos_valid) begin
      pos       <= load_pos;
      pos_valid <= 1'b1;
    end else begin
      unique case (step_cmd)
        STEP_UP:   if (pos != TOP_POS) pos <= pos + 1'b1;
        STEP_DOWN: if (pos != '0)      pos <= pos - 1'b1;
        default:   ;
      endcase
    end
  end

  // R4 / R5: index always inside the tap range
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= TOP_POS);

  // R2 / R3: a loaded counter moves by at most one place per clock
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid && $past(pos_valid) |->
      (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || (pos == $past(pos) - 1'b1));

  // R5: stepping down from zero keeps zero
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid && pos == '0 && step_cmd == STEP_DOWN |=> pos == '0);

endmodule

// File: rtl/wiper_nv_store.sv
module wiper_nv_store #(
  parameter int POS_W        = 7,
  parameter int BLANK_POS    = 50,
  parameter int STORE_CYCLES = 5_000_000,
  localparam int CNT_W       = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             rst_n,
  input  logic             store_req,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nv_pos,
  output logic             busy
);

  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(STORE_CYCLES);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)    nv_pos <= POS_W'(BLANK_POS);
    else if (store_req) nv_pos <= pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (store_req)        busy_cnt <= BUSY_LOAD;
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);

  // R7: a store captures the position and starts the busy interval
  a_r7_store_capture: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> busy && nv_pos == $past(pos));

  // R8: without a store request the retained value holds
  a_r8_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !store_req |=> $stable(nv_pos));

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int NUM_TAPS = 100,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input  logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tap_sel
);

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign tap_sel[t] = (pos == POS_W'(t));
  end

endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wiper_pkg::*;
#(
  parameter int NUM_TAPS     = 100,
  parameter int BLANK_POS    = 50,
  parameter int STORE_CYCLES = 5_000_000,
  localparam int POS_W       = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                cold_rst_n,
  input  logic                pwr_rst_n,
  input  logic                sel_n,
  input  logic                strobe,
  input  logic                dir_up,
  output logic [POS_W-1:0]    wiper_pos,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic                store_busy
);

  logic rst_n;
  assign rst_n = cold_rst_n & pwr_rst_n;

  ctl_t       ctl_raw, ctl_s, ctl_d;
  logic [2:0] sync_q;
  logic       strobe_fall, sel_rise, pos_valid, store_req;
  logic [POS_W-1:0] nv_pos;
  step_e      step_cmd;

  assign ctl_raw = '{sel_n: sel_n, strobe: strobe, dir_up: dir_up};

  wiper_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(CTL_IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctl_raw),
    .q_sync  (sync_q)
  );
  assign ctl_s = ctl_t'(sync_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_d <= CTL_IDLE;
    else        ctl_d <= ctl_s;
  end

  assign strobe_fall = ctl_d.strobe & ~ctl_s.strobe;
  assign sel_rise    = ~ctl_d.sel_n & ctl_s.sel_n;

  always_comb begin
    step_cmd = STEP_NONE;
    if (strobe_fall && !ctl_s.sel_n && !store_busy)
      step_cmd = ctl_s.dir_up ? STEP_UP : STEP_DOWN;
  end

  assign store_req = sel_rise & ctl_s.strobe & ~store_busy & pos_valid;

  wiper_step_ctr #(.NUM_TAPS(NUM_TAPS)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_pos  (nv_pos),
    .step_cmd  (step_cmd),
    .pos       (wiper_pos),
    .pos_valid (pos_valid)
  );

  wiper_nv_store #(
    .POS_W        (POS_W),
    .BLANK_POS    (BLANK_POS),
    .STORE_CYCLES (STORE_CYCLES)
  ) u_nv (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .rst_n      (rst_n),
    .store_req  (store_req),
    .pos        (wiper_pos),
    .nv_pos     (nv_pos),
    .busy       (store_busy)
  );

  wiper_tap_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .pos     (wiper_pos),
    .tap_sel (tap_sel)
  );

  // R9: while a store runs the position is frozen
  a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    store_busy |=> $stable(wiper_pos));

  // R10: exactly one tap, matching the position
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[wiper_pos]);

  // R6: deselected block never moves once loaded
  a_r6_deselect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid && ctl_s.sel_n |=> $stable(wiper_pos));

endmodule

// File: tb/test_wiper_pos_ctrl.sv
module test_wiper_pos_ctrl;

  localparam int NT    = 100;
  localparam int PW    = 7;
  localparam int STORE = 40;

  logic          clk = 1'b0;
  logic          cold_rst_n = 1'b0, pwr_rst_n = 1'b1;
  logic          sel_n = 1'b1, strobe = 1'b1, dir_up = 1'b0;
  logic [PW-1:0] wiper_pos;
  logic [NT-1:0] tap_sel;
  logic          store_busy;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wiper_pos_ctrl #(.NUM_TAPS(NT), .BLANK_POS(50), .STORE_CYCLES(STORE)) i_wiper_pos_ctrl (
    .clk(clk), .cold_rst_n(cold_rst_n), .pwr_rst_n(pwr_rst_n),
    .sel_n(sel_n), .strobe(strobe), .dir_up(dir_up),
    .wiper_pos(wiper_pos), .tap_sel(tap_sel), .store_busy(store_busy)
  );

  // {dir_up, pulse count, expected position}
  localparam logic [15:0] VEC [7] = '{
    {1'b1, 8'd3,   7'd53},  // R2
    {1'b0, 8'd5,   7'd48},  // R3
    {1'b1, 8'd60,  7'd99},  // R4
    {1'b1, 8'd2,   7'd99},  // R4
    {1'b0, 8'd120, 7'd0},   // R5
    {1'b0, 8'd1,   7'd0},   // R5
    {1'b1, 8'd7,   7'd7}    // R2
  };

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_tap(input int exp);
    n_chk++;
    if (tap_sel != (NT'(1) << exp)) begin
      n_bad++;
      $display("FAIL R10: actual %h expected bit %0d", tap_sel, exp);
    end
  endtask

  task automatic pulse(input logic up);
    dir_up = up;
    wait_n(2);
    strobe = 1'b0;
    wait_n(3);
    strobe = 1'b1;
    wait_n(3);
  endtask

  task automatic power_cycle();
    pwr_rst_n = 1'b0;
    wait_n(3);
    pwr_rst_n = 1'b1;
    wait_n(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait_n(100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    cold_rst_n = 1'b1;
    wait_n(6);
    chk("R1 blank recall", wiper_pos, 50);
    chk("R7 idle busy", store_busy, 0);
    chk_tap(50);

    sel_n = 1'b0;
    wait_n(3);
    for (int v = 0; v < 7; v++) begin
      for (int p = 0; p < int'(VEC[v][14:7]); p++) pulse(VEC[v][15]);
      chk("R2/R3/R4/R5 table", wiper_pos, int'(VEC[v][6:0]));
      chk_tap(int'(VEC[v][6:0]));
    end

    // R11: direction changes between pulses while selected
    pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    chk("R11 dir change", wiper_pos, 9);

    // R7: deselect with strobe high stores and raises busy
    sel_n = 1'b1;
    wait_n(4);
    chk("R7 busy on store", store_busy, 1);
    wait_n(STORE + 5);
    chk("R7 busy drops", store_busy, 0);

    // R6: strobes while deselected do nothing
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    chk("R6 deselected", wiper_pos, 9);

    power_cycle();
    chk("R1 R7 recall stored", wiper_pos, 9);

    // R9: strobes during busy are ignored
    sel_n = 1'b0;
    wait_n(3);
    pulse(1'b1);
    chk("R2 step", wiper_pos, 10);
    sel_n = 1'b1;
    wait_n(4);
    sel_n = 1'b0;
    wait_n(3);
    pulse(1'b1); pulse(1'b1);
    chk("R9 still busy", store_busy, 1);
    chk("R9 frozen", wiper_pos, 10);
    wait_n(STORE + 20);
    pulse(1'b1);
    chk("R9 resumes", wiper_pos, 11);

    // R8: deselect with strobe low discards
    dir_up = 1'b1;
    wait_n(2);
    strobe = 1'b0;
    wait_n(4);
    sel_n = 1'b1;
    wait_n(4);
    chk("R8 no busy", store_busy, 0);
    strobe = 1'b1;
    wait_n(4);
    chk("R8 live kept", wiper_pos, 12);
    power_cycle();
    chk("R8 not stored", wiper_pos, 10);

    // R1: cold reset blanks the retained value
    cold_rst_n = 1'b0;
    wait_n(3);
    cold_rst_n = 1'b1;
    wait_n(6);
    chk("R1 cold blank", wiper_pos, 50);
    chk_tap(50);

    finish_run();
  end

endmodule